// File: doc/BRIEF.md
# Host-Set Timestamp Unit

This block keeps device time for two mailbox commands. A free-running nanosecond counter advances by a fixed step each clock. A set command reads an 8-byte time value from a byte-addressed payload buffer. It records that value together with the counter reading taken when the command was accepted. A get command writes 8 bytes back into the same buffer: the recorded host time plus the nanoseconds counted since the set. Until the host has set the time at least once, a get writes zero.

The block does not keep a calendar of its own. All arithmetic wraps modulo 2^64. Commands arrive through a valid/ready handshake. A command is accepted on a clock edge where both `cmd_valid` and `cmd_ready` are high. `cmd_ready` stays low from acceptance until the cycle after `done`, so a requester that holds `cmd_valid` simply waits; nothing is lost or queued. The buffer port is a plain synchronous memory port: read data returns one cycle after `buf_rd_en`.

Top module: `host_time_unit`

## Requirements
- R1: After reset `cmd_ready` is 1, `done` is 0, and the buffer is neither read nor written until a command is accepted.
- R2: A get (`cmd_is_set`=0, length 0) issued before any set writes eight 0x00 bytes at payload offsets 0..7 and completes with return code 0x00 and output length 8.
- R3: A set (`cmd_is_set`=1, length 8) reads payload offsets 0..7 once each and never writes the buffer. Offset 0 is the least significant byte. It completes with return code 0x00 and output length 0.
- R4: A get after a set writes host + NS_PER_CLK × (cycles between the two acceptance edges), modulo 2^64. Byte k of the result goes to offset k, least significant byte first. It completes with return code 0x00 and output length 8.
- R5: A later set replaces both the host time and the captured counter, so elapsed time restarts from the new set.
- R6: A set whose length is not 8, or a get whose length is not 0, completes with return code 0x16 and output length 0. It makes no buffer access and leaves the stored time unchanged.
- R7: Each accepted command raises `done` for exactly one cycle. `cmd_ready` is low from acceptance through the `done` cycle and high again on the next cycle.
- R8: Sums that pass 2^64 wrap, and the low 64 bits are returned.
- R9: The internal counter advances by exactly NS_PER_CLK on every clock after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request present |
| cmd_ready | output | 1 | Unit idle and able to accept a command |
| cmd_is_set | input | 1 | 1 = set time, 0 = get time |
| cmd_len | input | 16 | Input payload length in bytes |
| done | output | 1 | One-cycle completion pulse |
| ret_code | output | 8 | Return code, valid while `done` is high |
| out_len | output | 16 | Output payload length, valid while `done` is high |
| buf_addr | output | ADDR_W | Payload byte address |
| buf_rd_en | output | 1 | Payload read strobe |
| buf_rdata | input | 8 | Payload read data, one cycle after the strobe |
| buf_wr_en | output | 1 | Payload write strobe |
| buf_wdata | output | 8 | Payload write data |

## Verification
Several properties are checked on every cycle:
- `done` never lasts more than one cycle.
- Reads occur only during a set and writes only during a get.
- Every byte written before the first set is zero.
- Once the valid flag is set it stays set.
- The counter steps by NS_PER_CLK on every clock.

Other behaviours need the bench's scenarios. These are the exact elapsed-time sum, the little-endian placement of the bytes, the restart on a repeated set, the wrap past 2^64, and the rule that a rejected command leaves the stored time untouched. The bench shows them by sweeping host values and idle gaps and comparing against arithmetic done in the bench.

// File: rtl/ts_pkg.sv
package ts_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_DONE  = 2'd3
  } ts_state_t;

  localparam int unsigned TIME_W     = 64;
  localparam int unsigned TIME_BYTES = TIME_W / 8;
  localparam logic [7:0]  RC_OK      = 8'h00;
  localparam logic [7:0]  RC_BAD_LEN = 8'h16;
  localparam logic [15:0] LEN_SET_IN = 16'(TIME_BYTES);
  localparam logic [15:0] LEN_GET_IN = 16'd0;
endpackage

// File: rtl/ts_ns_counter.sv
module ts_ns_counter #(
  parameter int unsigned WIDTH      = 64,
  parameter int unsigned NS_PER_CLK = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [WIDTH-1:0] now
);
  localparam logic [WIDTH-1:0] STEP = WIDTH'(NS_PER_CLK);

  logic [WIDTH-1:0] cnt_q;
  logic             armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_q + STEP;
      armed_q <= 1'b1;
    end
  end

  assign now = cnt_q;

  assert_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> (cnt_q == $past(cnt_q) + STEP));
endmodule

// File: rtl/ts_byte_walker.sv
module ts_byte_walker #(
  parameter int unsigned COUNT = 8,
  localparam int unsigned IDX_W = (COUNT > 1) ? $clog2(COUNT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  output logic             busy,
  output logic [IDX_W-1:0] idx,
  output logic             last
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(COUNT - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (go) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (busy) begin
      if (idx == LAST_IDX) busy <= 1'b0;
      else                 idx  <= idx + 1'b1;
    end
  end

  assign last = busy && (idx == LAST_IDX);
endmodule

// File: rtl/ts_time_store.sv
module ts_time_store #(
  parameter int unsigned WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic [WIDTH-1:0] host_in,
  input  logic [WIDTH-1:0] cap_in,
  input  logic [WIDTH-1:0] now,
  output logic             valid,
  output logic [WIDTH-1:0] result
);
  logic [WIDTH-1:0] host_q;
  logic [WIDTH-1:0] cap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      host_q <= '0;
      cap_q  <= '0;
    end else if (commit) begin
      valid  <= 1'b1;
      host_q <= host_in;
      cap_q  <= cap_in;
    end
  end

  assign result = valid ? (host_q + (now - cap_q)) : '0;

  assert_valid_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> valid);
endmodule

// File: rtl/host_time_unit.sv
module host_time_unit
  import ts_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned BASE_ADDR  = 0,
  parameter int unsigned NS_PER_CLK = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_is_set,
  input  logic [15:0]       cmd_len,
  output logic              done,
  output logic [7:0]        ret_code,
  output logic [15:0]       out_len,
  output logic [ADDR_W-1:0] buf_addr,
  output logic              buf_rd_en,
  input  logic [7:0]        buf_rdata,
  output logic              buf_wr_en,
  output logic [7:0]        buf_wdata
);
  localparam int unsigned IDX_W = $clog2(TIME_BYTES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TIME_BYTES - 1);

  ts_state_t          st_q;
  logic               op_set_q;
  logic [TIME_W-1:0]  shadow_q;
  logic [TIME_W-1:0]  cap_pend_q;
  logic [TIME_W-1:0]  merged;
  logic [TIME_W-1:0]  now;
  logic [TIME_W-1:0]  result;
  logic               ts_valid;
  logic [7:0]         rc_q;
  logic [15:0]        olen_q;
  logic               rd_v_q;
  logic [IDX_W-1:0]   rd_i_q;
  logic               accept, len_ok, go, commit;
  logic               walk_busy, walk_last;
  logic [IDX_W-1:0]   walk_idx;

  ts_ns_counter #(.WIDTH(TIME_W), .NS_PER_CLK(NS_PER_CLK)) u_cnt (
    .clk(clk), .rst_n(rst_n), .now(now)
  );

  ts_byte_walker #(.COUNT(TIME_BYTES)) u_walk (
    .clk(clk), .rst_n(rst_n), .go(go),
    .busy(walk_busy), .idx(walk_idx), .last(walk_last)
  );

  ts_time_store #(.WIDTH(TIME_W)) u_store (
    .clk(clk), .rst_n(rst_n), .commit(commit),
    .host_in(merged), .cap_in(cap_pend_q), .now(now),
    .valid(ts_valid), .result(result)
  );

  assign cmd_ready = (st_q == ST_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign len_ok    = cmd_is_set ? (cmd_len == LEN_SET_IN) : (cmd_len == LEN_GET_IN);
  assign go        = accept && len_ok;
  assign commit    = rd_v_q && (rd_i_q == LAST_IDX);

  always_comb begin
    merged = shadow_q;
    merged[{rd_i_q, 3'b000} +: 8] = buf_rdata;
  end

  assign buf_rd_en = (st_q == ST_READ)  && walk_busy;
  assign buf_wr_en = (st_q == ST_WRITE) && walk_busy;
  assign buf_addr  = ADDR_W'(BASE_ADDR) + ADDR_W'(walk_idx);
  assign buf_wdata = shadow_q[{walk_idx, 3'b000} +: 8];

  assign done     = (st_q == ST_DONE);
  assign ret_code = rc_q;
  assign out_len  = olen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      op_set_q   <= 1'b0;
      shadow_q   <= '0;
      cap_pend_q <= '0;
      rc_q       <= RC_OK;
      olen_q     <= '0;
      rd_v_q     <= 1'b0;
      rd_i_q     <= '0;
    end else begin
      rd_v_q <= buf_rd_en;
      rd_i_q <= walk_idx;
      unique case (st_q)
        ST_IDLE: if (accept) begin
          op_set_q <= cmd_is_set;
          if (!len_ok) begin
            rc_q   <= RC_BAD_LEN;
            olen_q <= '0;
            st_q   <= ST_DONE;
          end else if (cmd_is_set) begin
            cap_pend_q <= now;
            st_q       <= ST_READ;
          end else begin
            shadow_q <= result;
            st_q     <= ST_WRITE;
          end
        end
        ST_READ: begin
          if (rd_v_q) shadow_q <= merged;
          if (commit) begin
            rc_q   <= RC_OK;
            olen_q <= '0;
            st_q   <= ST_DONE;
          end
        end
        ST_WRITE: if (walk_last) begin
          rc_q   <= RC_OK;
          olen_q <= 16'(TIME_BYTES);
          st_q   <= ST_DONE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_read_only_on_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    buf_rd_en |-> (op_set_q && !buf_wr_en));
  assert_write_only_on_get_R4: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr_en |-> !op_set_q);
  assert_zero_before_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_wr_en && !ts_valid) |-> (buf_wdata == 8'h00));
  assert_idle_no_access_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !(buf_rd_en || buf_wr_en));
  assert_bad_len_zero_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ret_code == RC_BAD_LEN) |-> (out_len == 16'd0));
endmodule

// File: tb/test_host_time_unit.sv
module test_host_time_unit;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned NS     = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_is_set = 1'b0;
  logic [15:0] cmd_len = '0;
  logic        cmd_ready, done, buf_rd_en, buf_wr_en;
  logic [7:0]  ret_code, buf_wdata;
  logic [7:0]  buf_rdata;
  logic [15:0] out_len;
  logic [ADDR_W-1:0] buf_addr;

  logic [7:0]  mem [16];
  logic        tb_we = 1'b0;
  logic [3:0]  tb_a = '0;
  logic [7:0]  tb_d = '0;
  int          rd_cnt = 0;
  int          wr_cnt = 0;
  longint      cyc = 0;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  host_time_unit #(.ADDR_W(ADDR_W), .BASE_ADDR(0), .NS_PER_CLK(NS)) i_host_time_unit (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_is_set(cmd_is_set), .cmd_len(cmd_len), .done(done), .ret_code(ret_code),
    .out_len(out_len), .buf_addr(buf_addr), .buf_rd_en(buf_rd_en),
    .buf_rdata(buf_rdata), .buf_wr_en(buf_wr_en), .buf_wdata(buf_wdata)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (tb_we) mem[tb_a] <= tb_d;
    if (buf_wr_en) begin
      mem[buf_addr] <= buf_wdata;
      wr_cnt <= wr_cnt + 1;
    end
    if (buf_rd_en) begin
      buf_rdata <= mem[buf_addr];
      rd_cnt <= rd_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(input logic [63:0] v);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      tb_we = 1'b1; tb_a = 4'(i); tb_d = v[8*i +: 8];
    end
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  function automatic logic [63:0] mem_val();
    logic [63:0] r;
    for (int i = 0; i < 8; i++) r[8*i +: 8] = mem[i];
    return r;
  endfunction

  // Issue one command and check handshake, completion and access counts.
  task automatic run(input bit is_set, input logic [15:0] len, input logic [7:0] exp_rc,
                     input logic [15:0] exp_ol, input int exp_rd, input int exp_wr,
                     input string req, output longint acc);
    int rd0, wr0, waited;
    bit busy_ok;
    @(negedge clk);
    rd0 = rd_cnt; wr0 = wr_cnt;
    cmd_valid = 1'b1; cmd_is_set = is_set; cmd_len = len;
    @(posedge clk);
    #1;
    acc = cyc;
    cmd_valid = 1'b0;
    waited = 0;
    busy_ok = 1'b1;
    forever begin
      @(negedge clk);
      if (done || waited > 40) break;
      if (cmd_ready) busy_ok = 1'b0;
      waited++;
    end
    chk(done == 1'b1, {req, " R7 done seen"}, 64'(done), 64'd1);
    chk(busy_ok && !cmd_ready, {req, " R7 ready low while busy"}, 64'(cmd_ready), 64'd0);
    chk(ret_code == exp_rc, {req, " ret_code"}, 64'(ret_code), 64'(exp_rc));
    chk(out_len == exp_ol, {req, " out_len"}, 64'(out_len), 64'(exp_ol));
    @(negedge clk);
    chk(!done && cmd_ready, {req, " R7 single-cycle done"}, {62'd0, done, cmd_ready}, 64'd1);
    chk(rd_cnt - rd0 == exp_rd, {req, " reads"}, 64'(rd_cnt - rd0), 64'(exp_rd));
    chk(wr_cnt - wr0 == exp_wr, {req, " writes"}, 64'(wr_cnt - wr0), 64'(exp_wr));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] hosts [6];
    logic [63:0] exp, host;
    longint a_set, a_get, a_tmp;
    hosts[0] = 64'h0;
    hosts[1] = 64'h0123_4567_89AB_CDEF;
    hosts[2] = 64'hFFFF_FFFF_FFFF_FFF0;
    hosts[3] = 64'h8000_0000_0000_0000;
    hosts[4] = 64'h0000_0000_FFFF_FFFE;
    hosts[5] = 64'hFFFF_FFFF_FFFF_FFFF;

    for (int i = 0; i < 16; i++) mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(cmd_ready && !done, "R1 reset ready/done", {62'd0, cmd_ready, done}, 64'd2);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(cmd_ready && !done && rd_cnt == 0 && wr_cnt == 0, "R1 idle no access",
        64'(rd_cnt + wr_cnt), 64'd0);

    // R6: bad-length get before any set
    run(1'b0, 16'd8, 8'h16, 16'd0, 0, 0, "R6 get len8", a_tmp);
    // R2: get before any set writes zeros over 0xFF
    run(1'b0, 16'd0, 8'h00, 16'd8, 0, 8, "R2 get unset", a_tmp);
    chk(mem_val() == 64'd0, "R2 zero payload", mem_val(), 64'd0);

    // R3/R4/R5/R8: sweep host values and gaps
    for (int h = 0; h < 6; h++) begin
      for (int g = 0; g < 4; g++) begin
        host = hosts[h] ^ 64'(g * 64'h0101);
        load(host);
        run(1'b1, 16'd8, 8'h00, 16'd0, 8, 0, "R3 set", a_set);
        repeat (g * 5) @(negedge clk);
        run(1'b0, 16'd0, 8'h00, 16'd8, 0, 8, "R4 get", a_get);
        exp = host + 64'(a_get - a_set) * 64'(NS);
        chk(mem_val() == exp, (h == 2 || h == 5) ? "R8 wrap get value" : "R5 R4 get value",
            mem_val(), exp);
      end
    end

    // R6: rejected sets leave stored time unchanged
    host = 64'h1122_3344_5566_7788;
    load(host);
    run(1'b1, 16'd8, 8'h00, 16'd0, 8, 0, "R3 set base", a_set);
    for (int k = 0; k < 4; k++) begin
      logic [15:0] bl;
      bl = (k == 0) ? 16'd0 : (k == 1) ? 16'd7 : (k == 2) ? 16'd9 : 16'hFFFF;
      load(64'hDEAD_BEEF_0000_0000 | 64'(k));
      run(1'b1, bl, 8'h16, 16'd0, 0, 0, "R6 set bad len", a_tmp);
      run(1'b0, 16'd1, 8'h16, 16'd0, 0, 0, "R6 get bad len", a_tmp);
      run(1'b0, 16'd0, 8'h00, 16'd8, 0, 8, "R6 get after reject", a_get);
      exp = host + 64'(a_get - a_set) * 64'(NS);
      chk(mem_val() == exp, "R6 stored time kept", mem_val(), exp);
    end

    // R9: two back-to-back gets differ by NS times the acceptance spacing
    run(1'b0, 16'd0, 8'h00, 16'd8, 0, 8, "R9 get a", a_set);
    exp = mem_val();
    run(1'b0, 16'd0, 8'h00, 16'd8, 0, 8, "R9 get b", a_get);
    chk(mem_val() - exp == 64'(a_get - a_set) * 64'(NS), "R9 counter step",
        mem_val() - exp, 64'(a_get - a_set) * 64'(NS));

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule